// File: doc/BRIEF.md
# Write-Completion Status Poller

This block runs on the host side of a byte-wide non-volatile memory. Once a page write or a chip erase has been launched, the memory runs its internal write cycle on its own. The poller finds out when that cycle has finished. It is started in the cycle when the load strobe that launches the internal cycle ends. It latches the address and the data byte of the last load, then reads that location again and again through a simple read port. The port holds a request until the memory returns one valid byte.

Two detection methods are available. In complement-data mode, the poller compares bit 7 of each status byte with bit 7 of the byte that was written: while the write is in progress, the memory returns that bit inverted. In toggle mode, the poller watches bit 6, which alternates from read to read while the write is in progress and then holds steady. An erase always uses toggle mode. A status read can coincide with the end of the write and so give a misleading result. For that reason, a candidate completion is accepted only when the next two reads confirm it. A poll limit ends a run that never settles and flags an error.

Top module: `wrpoll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `rd_req_o` are all 0.
- R2: A `start_i` pulse while idle makes `busy_o` and `rd_req_o` 1 in the next cycle, with `rd_addr_o` equal to the `addr_i` value captured at start.
- R3: In complement-data mode (`mode_tgl_i`=0, `erase_i`=0), a read matches when its bit 7 equals bit 7 of `data_i` captured at start. Done is reported on the third consecutive matching read: one candidate plus two confirmations.
- R4: In toggle mode, a read matches when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run never matches. Done is reported on the third consecutive matching read, which is four reads with equal bit 6.
- R5: A non-matching read inside a confirmation restarts the count. A lone false completion during the busy window therefore does not produce done.
- R6: `erase_i`=1 at start selects toggle mode whatever the value of `mode_tgl_i`.
- R7: If the limit of MAX_POLLS reads is reached without completion, the run ends with `err_o`=1 after exactly MAX_POLLS reads. `err_o` stays 1 until the next accepted start.
- R8: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. `done_o` and `err_o` are never both 1.
- R9: `start_i` is ignored while `busy_o`=1. The address, the mode and the outcome of the run in progress are unchanged.
- R10: No read is requested once a run has ended: `rd_req_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling; taken only while idle |
| mode_tgl_i | input | 1 | 1 selects toggle mode, 0 selects complement-data mode |
| erase_i | input | 1 | Operation was a chip erase; forces toggle mode |
| addr_i | input | AW | Location of the last byte loaded |
| data_i | input | 8 | Last byte loaded |
| rd_req_o | output | 1 | Read request, held until `rd_valid_i` |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | 8 | Returned status byte |
| rd_valid_i | input | 1 | `rd_data_i` is valid; completes one read |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll limit reached without completion |

## Verification
The memory's busy window is swept over every length from zero up to past the poll limit, in each of the three mode settings. Two data bytes with opposite bits 7 and 6 are used, so the read counts of complement-data and toggle detection differ, and the final busy read either agrees or disagrees with the settled bit 6. A second pass places a single true-data read inside the busy window, which tells a design that confirms a candidate apart from one that trusts it. Erase runs with complement-data mode selected show whether the forced toggle method is applied, and a start pulse during every run shows whether the address, the mode or the read count is disturbed.

// File: rtl/wrpoll_ctrl.sv
module wrpoll_ctrl #(
  parameter int AW = 16,
  parameter int MAX_POLLS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_tgl_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  input  logic          rd_valid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic          busy_q, tgl_q, exp7_q, prev6_q, have_prev_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    streak_q;
  logic [CW-1:0] cnt_q;
  logic          match, settle;

  assign match  = tgl_q ? (have_prev_q && rd_data_i[6] == prev6_q)
                        : (rd_data_i[7] == exp7_q);
  assign settle = match && streak_q == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      tgl_q       <= 1'b0;
      exp7_q      <= 1'b0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      addr_q      <= '0;
      streak_q    <= '0;
      cnt_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q      <= 1'b1;
          addr_q      <= addr_i;
          exp7_q      <= data_i[7];
          tgl_q       <= mode_tgl_i | erase_i;
          have_prev_q <= 1'b0;
          streak_q    <= '0;
          cnt_q       <= '0;
          err_q       <= 1'b0;
        end
      end else if (rd_valid_i) begin
        prev6_q     <= rd_data_i[6];
        have_prev_q <= 1'b1;
        cnt_q       <= cnt_q + 1'b1;
        streak_q    <= match ? streak_q + 2'd1 : 2'd0;
        if (settle) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign rd_req_o  = busy_q;
  assign rd_addr_o = addr_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/wrpoll_ctrl_chk.sv
module wrpoll_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!busy_o && $past(busy_o)));
  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o));
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) err_o |-> !busy_o);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> (busy_o && rd_req_o));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
  // R10
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !rd_req_o);
endmodule

bind wrpoll_ctrl wrpoll_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/wrpoll_ctrl_tb.sv
module wrpoll_ctrl_tb;
  localparam int AW = 8;
  localparam int MAXP = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, mode_tgl_i = 1'b0, erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0, rd_data_i = '0;
  logic rd_valid_i = 1'b0;
  logic rd_req_o, busy_o, done_o, err_o;
  logic [AW-1:0] rd_addr_o;

  int total = 0, bad = 0, cycles = 0, nreads = 0, base = 0;
  int cur_w = 0, cur_g = -1;
  logic [7:0] cur_d = '0;

  wrpoll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_tgl_i(mode_tgl_i),
    .erase_i(erase_i), .addr_i(addr_i), .data_i(data_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] seqv(int i);
    if (i < cur_w && i != cur_g) return {~cur_d[7], (i % 2 == 0), cur_d[5:0]};
    return cur_d;
  endfunction

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rd_req_o && !rd_valid_i) begin
      rd_data_i  <= seqv(nreads - base);
      rd_valid_i <= 1'b1;
      nreads     <= nreads + 1;
    end else rd_valid_i <= 1'b0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_run(bit tgl, output bit ok, output int n);
    int run = 0;
    bit p = 0;
    bit m;
    ok = 0;
    n = MAXP;
    for (int i = 0; i < MAXP; i++) begin
      logic [7:0] v = seqv(i);
      m = tgl ? (i > 0 && v[6] == p) : (v[7] == cur_d[7]);
      p = v[6];
      run = m ? run + 1 : 0;
      if (run == 3) begin
        ok = 1;
        n = i + 1;
        break;
      end
    end
  endtask

  task automatic run_case(int md, int w, logic [7:0] d, int g, logic [AW-1:0] a);
    bit ok;
    int n, waited;
    cur_w = w; cur_d = d; cur_g = g; base = nreads;
    expect_run(md != 0, ok, n);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d;
    mode_tgl_i = (md == 1); erase_i = (md == 2);
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy", busy_o, 1);
    check("R2 addr", rd_addr_o, a);
    start_i = 1'b1; addr_i = ~a; data_i = ~d; mode_tgl_i = ~mode_tgl_i; erase_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && !err_o && waited < 200) begin
      @(negedge clk);
      waited++;
      if (busy_o && rd_addr_o !== a) check("R9 addr held", rd_addr_o, a);
    end
    if (md == 2) check("R6 erase uses toggle", {done_o, 31'(nreads - base)}, {ok, 31'(n)});
    else if (g >= 0) check("R5 glitch rejected", {done_o, 31'(nreads - base)}, {ok, 31'(n)});
    else if (md == 1) check("R4 toggle result", {done_o, 31'(nreads - base)}, {ok, 31'(n)});
    else check("R3 poll result", {done_o, 31'(nreads - base)}, {ok, 31'(n)});
    if (!ok) check("R7 err", {err_o, 31'(nreads - base)}, {1'b1, 31'(MAXP)});
    check("R9 outcome kept", {done_o, err_o}, {ok, !ok});
    @(negedge clk);
    check("R8 done pulse", done_o, 0);
    check("R10 no req", rd_req_o, 0);
    if (!ok) check("R7 err held", err_o, 1);
    @(negedge clk);
    check("R10 no extra read", 32'(nreads - base), 32'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);
    check("R1 req", rd_req_o, 0);
    rst_n = 1'b1;
    for (int md = 0; md < 3; md++)
      for (int w = 0; w <= MAXP; w++)
        for (int k = 0; k < 2; k++) begin
          logic [7:0] d = k ? 8'h4C : 8'hA5;
          run_case(md, w, d, -1, AW'(w * 7 + md));
          if (w > 2) run_case(md, w, d, w / 2, AW'(w * 3 + k));
        end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule